// File: doc/BRIEF.md
# Palette DAC Hidden Command Register

This block is the host-facing register file of a direct-colour capable palette DAC that sits on an 8-bit I/O bus with four byte addresses: pixel mask (0), read index (1), write index (2) and palette data (3). The palette RAM behind addresses 1 to 3 lives elsewhere. Here those addresses are only decoded, and any access to them is observed.

A mode command register has no address of its own. The host reaches it by reading the pixel mask address several times in a row. Once armed, reads and writes at the mask address are steered to the command register instead of the mask. Touching any other address returns the mask address to the pixel mask. The stored command byte drives the mode outputs: direct-colour enable, 16-bit pixel format and two-clock byte latching.

Top module: `pal_cmd_regs`

## Requirements
- R1: After reset the command register is 0x00, the pixel mask is 0xFF and the block is not armed, so a read at address 0 returns 0xFF and all three mode outputs are 0.
- R2: After exactly UNLOCK_READS (default 4) consecutive reads at address 0, the block is armed. With fewer reads it stays unarmed, and each of those reads returns the pixel mask.
- R3: While armed, a read at address 0 returns the command register, and the block stays armed.
- R4: While armed, a write at address 0 loads the command register and leaves the pixel mask unchanged.
- R5: A read or write at address 1, 2 or 3 disarms the block and restarts the read count from zero.
- R6: A write at address 0 while unarmed restarts the read count from zero.
- R7: While unarmed, a write at address 0 loads the pixel mask (visible on pix_mask the next cycle) and leaves the command register unchanged.
- R8: hicolor_en equals command bit 7, one cycle after the command write.
- R9: mode16 equals command bit 6 (1 selects 5-6-5 pixels, 0 selects 5-5-5).
- R10: two_clk_latch equals command bit 5 (1 selects two-clock latching, 0 selects double-edge latching).
- R11: rdata is 0x00 whenever addr is 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Byte address: 0 mask, 1 read index, 2 write index, 3 data |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| pix_mask | output | 8 | Pixel mask register |
| hicolor_en | output | 1 | Direct-colour mode enable |
| mode16 | output | 1 | 16-bit pixel format select |
| two_clk_latch | output | 1 | Two-clock byte latch select |

## Verification
The bench builds the block with its defaults: an 8-bit bus and an unlock length of four reads. With these values, random runs of mask reads often reach the arming count, and they are also often broken off one short of it by a neighbour access or a mask write. Those near misses are where the counter is most likely to go wrong. Directed sequences cover reset values, a run of three reads followed by an index access, a mask write in the middle of a count, and a probe that reads back the command byte after the register has been unlocked.

// File: rtl/pal_cmd_regs.sv
module pal_cmd_regs #(
  parameter int DW = 8,
  parameter int UNLOCK_READS = 4,
  parameter logic [DW-1:0] MASK_RST = '1,
  parameter logic [DW-1:0] CMD_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] pix_mask,
  output logic          hicolor_en,
  output logic          mode16,
  output logic          two_clk_latch
);
  localparam int CW = $clog2(UNLOCK_READS + 1);
  localparam logic [CW-1:0] FULL = CW'(UNLOCK_READS);

  logic [CW-1:0] cnt;
  logic [DW-1:0] cmd;
  logic          armed, at_mask, access;

  assign armed   = (cnt == FULL);
  assign at_mask = (addr == 2'd0);
  assign access  = rd_en | wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmd      <= CMD_RST;
      pix_mask <= MASK_RST;
    end else if (access && !at_mask) begin
      cnt <= '0;
    end else if (wr_en) begin
      if (armed) cmd <= wdata;
      else begin
        pix_mask <= wdata;
        cnt      <= '0;
      end
    end else if (rd_en && !armed) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign rdata         = at_mask ? (armed ? cmd : pix_mask) : '0;
  assign hicolor_en    = cmd[7];
  assign mode16        = cmd[6];
  assign two_clk_latch = cmd[5];

  assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !at_mask) |=> (cnt == '0));
  assert_mask_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_mask && armed) |=> $stable(pix_mask));
  assert_cmd_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_mask && !armed) |=> $stable(cmd));
  assert_arm_by_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(rd_en && !wr_en && at_mask));
  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && at_mask && !armed) |=> (cnt == '0));
endmodule

// File: tb/sim_pal_cmd_regs.sv
module sim_pal_cmd_regs;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0, rdata, pix_mask;
  logic hicolor_en, mode16, two_clk_latch;
  int checks = 0, failures = 0;
  bit done = 0;
  int m_cnt;
  logic [7:0] m_mask, m_cmd;

  always #2 clk = ~clk;

  pal_cmd_regs u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pix_mask(pix_mask), .hicolor_en(hicolor_en),
    .mode16(mode16), .two_clk_latch(two_clk_latch));

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    if (a != 2'd0) return 8'h00;
    return (m_cnt == 4) ? m_cmd : m_mask;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R7 pix_mask", pix_mask, m_mask);
    chk("R8 hicolor_en", {7'd0, hicolor_en}, {7'd0, m_cmd[7]});
    chk("R9 mode16", {7'd0, mode16}, {7'd0, m_cmd[6]});
    chk("R10 two_clk_latch", {7'd0, two_clk_latch}, {7'd0, m_cmd[5]});
  endtask

  task automatic acc(input logic [1:0] a, input bit wr, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = wr; rd_en = !wr; wdata = d;
    #1;
    if (!wr) chk(a == 0 ? "R2/R3 read mask addr" : "R11 read other addr", rdata, exp_rd(a));
    @(posedge clk);
    if (a != 0) m_cnt = 0;
    else if (wr) begin
      if (m_cnt == 4) m_cmd = d;
      else begin m_mask = d; m_cnt = 0; end
    end else if (m_cnt < 4) m_cnt++;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    check_outs();
  endtask

  task automatic unlock();
    acc(2'd2, 0, 0);
    for (int i = 0; i < 4; i++) acc(2'd0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    m_cnt = 0; m_mask = 8'hFF; m_cmd = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask reset", pix_mask, 8'hFF);
    chk("R1 rdata", rdata, 8'hFF);
    chk("R1 modes", {hicolor_en, mode16, two_clk_latch}, 8'h00);
    // R2 three reads then index access: not armed
    for (int i = 0; i < 3; i++) acc(2'd0, 0, 0);
    acc(2'd1, 0, 0);
    acc(2'd0, 0, 0);
    chk("R5 still unarmed", rdata, m_mask);
    // R6 mask write mid-count
    acc(2'd2, 0, 0);
    acc(2'd0, 0, 0); acc(2'd0, 0, 0);
    acc(2'd0, 1, 8'h3C);
    for (int i = 0; i < 3; i++) acc(2'd0, 0, 0);
    acc(2'd0, 0, 0);
    // R3/R4 probe: write command, read back
    acc(2'd0, 1, 8'hE0);
    acc(2'd0, 0, 0);
    chk("R4 mask untouched", pix_mask, 8'h3C);
    acc(2'd3, 1, 8'h11);
    acc(2'd0, 0, 0);
    unlock();
    acc(2'd0, 1, 8'h40);
    acc(2'd0, 0, 0);
    unlock();
    acc(2'd0, 1, 8'hA0);
    acc(2'd1, 1, 8'h00);
    acc(2'd0, 1, 8'h55);
    // random
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      logic [1:0] a = (r < 75) ? 2'd0 : 2'($urandom_range(1, 3));
      bit w = ($urandom_range(0, 99) < 20);
      acc(a, w, 8'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule